// File: doc/BRIEF.md
# Inbound Request Error Checker

This block sits on the master side of a bridge that carries PCI Express requests onto a local bus. For every request header that arrives from the remote requester, it chooses one of four outcomes. The request can be forwarded to the local bus. It can be dropped silently. It can be dropped with an Unsupported Request completion sent back. Or it can be dropped as poisoned. The block also pulses a small set of interrupt lines. A separate path takes the local bus's reports on requests that were already forwarded, and turns timeouts and read errors into Completer Abort completions.

The header arrives already decoded: format, type, address, poison flag and tag. Three address windows are set through configuration inputs. Each window has a base, a compare mask and an enable. The checks run in strict priority order. The request type is checked first, then the window match, then the poison flag, and the first failure decides the outcome. Every result is registered and appears one clock after the input that caused it. Completions leave as requests that carry a tag and a 3-bit status code. Building the actual completion packets is left to a downstream block.

Top module: `inb_req_checker`

## Requirements
- R1: After reset, and in any cycle that follows a cycle with no header or local-bus input, all valid and interrupt outputs are 0.
- R2: A memory request (type 5'b00000, fmt[2]=0; fmt[1]=1 means write) that hits an enabled window and is not poisoned produces fwd_valid one clock after hdr_valid. The forwarded address, tag, window index and write flag are taken from that header, fwd_np is set for reads, and no completion or interrupt is produced.
- R3: A window hits when ((addr ^ base) & mask) == 0 and its enable bit is 1. A disabled window never hits, and when several windows hit, the lowest-numbered one is reported.
- R4: A memory request that misses every window is dropped. A read (non-posted) then gets a completion with status 3'b001 (Unsupported Request) and the request's tag. A write (posted) gets no completion.
- R5: An I/O request (type 5'b00010) is dropped with a status 3'b001 completion, whether or not it hits a window, and raises no interrupt.
- R6: A message (type[4:3]=2'b10, fmt[0]=1, fmt[2]=0) is dropped with no completion. If its routing field type[2:0] is 3'b001 (routed by address), irq_unsup pulses for one cycle. Messages with any other routing raise nothing.
- R7: Any other type or format (for example type 5'b00100, or fmt[2]=1) is treated as non-posted and unsupported: it is dropped with a status 3'b001 completion and no interrupt.
- R8: Checks stop at the first failure. A request that fails the type check or the window check never raises irq_poison, even when its poison flag is set.
- R9: A poisoned memory request that passes the type and window checks is not forwarded, gets no completion, and pulses irq_poison for one cycle.
- R10: A local-bus timeout report pulses irq_abort one clock later. If the timed-out request was non-posted, a completion with status 3'b100 (Completer Abort) and the reported tag is issued in that same cycle.
- R11: A local-bus read-error report (without a timeout) issues a status 3'b100 completion with the reported tag one clock later and does not pulse irq_abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Decoded request header present this cycle |
| hdr_fmt | input | 3 | Header format field |
| hdr_type | input | 5 | Header type field |
| hdr_addr | input | ADDR_W | Request address |
| hdr_poison | input | 1 | Poisoned-data flag from the header |
| hdr_tag | input | TAG_W | Requester tag |
| cfg_bar_en | input | NUM_BAR | Per-window enable |
| cfg_bar_base | input | NUM_BAR*ADDR_W | Window bases, window 0 in the low bits |
| cfg_bar_mask | input | NUM_BAR*ADDR_W | Window compare masks (1 = bit compared) |
| lb_rsp_valid | input | 1 | Local-bus outcome report for a forwarded request |
| lb_rsp_timeout | input | 1 | The local bus timed out |
| lb_rsp_rderr | input | 1 | The local-bus target returned a read error |
| lb_rsp_np | input | 1 | The reported request was non-posted |
| lb_rsp_tag | input | TAG_W | Tag of the reported request |
| fwd_valid | output | 1 | Forward request to the local bus |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_tag | output | TAG_W | Forwarded tag |
| fwd_bar | output | BAR_IDX_W | Index of the window that matched |
| fwd_write | output | 1 | Forwarded request is a write |
| fwd_np | output | 1 | Forwarded request is non-posted |
| hdr_cpl_valid | output | 1 | Completion request from a rejected header |
| hdr_cpl_status | output | 3 | Its completion status |
| hdr_cpl_tag | output | TAG_W | Its tag |
| lb_cpl_valid | output | 1 | Completion request from a local-bus failure |
| lb_cpl_status | output | 3 | Its completion status |
| lb_cpl_tag | output | TAG_W | Its tag |
| irq_unsup | output | 1 | Address-routed message rejected (pulse) |
| irq_abort | output | 1 | Local-bus timeout (pulse) |
| irq_poison | output | 1 | Poisoned request dropped (pulse) |

## Verification
The bench targets the ordering corner cases. It sends poisoned requests that also carry a bad type or miss every window. A design that checked poison too early would pulse irq_poison on these, or would swallow the Unsupported Request completion. It sends I/O requests that hit a window and address-routed messages. A design that mixed up the two would raise irq_unsup on the I/O request or send a completion for a posted message. Overlapping windows are used, along with a window that is disabled while its range still matches. A design with a broken priority encoder would report the wrong index, and one that ignored the enable would forward where it should reject. On the local-bus side, timeouts on posted and non-posted requests are checked alongside plain read errors. A design that treated them the same would send a completion for a posted write or pulse irq_abort on a read error.

// File: rtl/ireq_pkg.sv
package ireq_pkg;

  typedef enum logic [1:0] {
    KIND_MEM   = 2'd0,
    KIND_IO    = 2'd1,
    KIND_MSG   = 2'd2,
    KIND_OTHER = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    DEC_NONE        = 3'd0,
    DEC_FORWARD     = 3'd1,
    DEC_DROP_SILENT = 3'd2,
    DEC_DROP_UR     = 3'd3,
    DEC_DROP_POISON = 3'd4
  } decision_e;

  localparam logic [2:0] CPL_SC = 3'b000;
  localparam logic [2:0] CPL_UR = 3'b001;
  localparam logic [2:0] CPL_CA = 3'b100;

  localparam logic [4:0] TYPE_MEM    = 5'b00000;
  localparam logic [4:0] TYPE_IO     = 5'b00010;
  localparam logic [1:0] TYPE_MSG_HI = 2'b10;
  localparam logic [2:0] ROUTE_ADDR  = 3'b001;

  // Sort a header into one of four request kinds from format and type.
  function automatic req_kind_e decode_kind(input logic [2:0] fmt, input logic [4:0] typ);
    req_kind_e k;
    if (fmt[2])
      k = KIND_OTHER;
    else if (typ == TYPE_MEM)
      k = KIND_MEM;
    else if (typ == TYPE_IO)
      k = KIND_IO;
    else if (typ[4:3] == TYPE_MSG_HI && fmt[0])
      k = KIND_MSG;
    else
      k = KIND_OTHER;
    return k;
  endfunction

  // Posted requests: memory writes and messages; everything else waits for a completion.
  function automatic logic is_posted(input req_kind_e kind, input logic [2:0] fmt);
    return (kind == KIND_MEM && fmt[1]) || (kind == KIND_MSG);
  endfunction

endpackage

// File: rtl/ireq_classify.sv
module ireq_classify
  import ireq_pkg::*;
(
  input  logic [2:0] fmt,
  input  logic [4:0] typ,
  output req_kind_e  kind,
  output logic       posted,
  output logic       is_write,
  output logic       msg_by_addr
);

  always_comb begin
    kind        = decode_kind(fmt, typ);
    posted      = is_posted(kind, fmt);
    is_write    = fmt[1];
    msg_by_addr = (kind == KIND_MSG) && (typ[2:0] == ROUTE_ADDR);
  end

endmodule

// File: rtl/ireq_bar_match.sv
module ireq_bar_match #(
  parameter int ADDR_W    = 32,
  parameter int NUM_BAR   = 3,
  parameter int BAR_IDX_W = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1
) (
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NUM_BAR-1:0]        bar_en,
  input  logic [NUM_BAR*ADDR_W-1:0] bar_base,
  input  logic [NUM_BAR*ADDR_W-1:0] bar_mask,
  output logic [NUM_BAR-1:0]        hit_vec,
  output logic [NUM_BAR-1:0]        first_vec,
  output logic                      any_hit,
  output logic [BAR_IDX_W-1:0]      hit_idx
);

  function automatic logic window_hit(input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] base,
                                      input logic [ADDR_W-1:0] mask,
                                      input logic en);
    return en && (((a ^ base) & mask) == '0);
  endfunction

  for (genvar g = 0; g < NUM_BAR; g++) begin : g_win
    assign hit_vec[g] = window_hit(addr,
                                   bar_base[g*ADDR_W +: ADDR_W],
                                   bar_mask[g*ADDR_W +: ADDR_W],
                                   bar_en[g]);
    if (g == 0) begin : g_lowest
      assign first_vec[g] = hit_vec[g];
    end else begin : g_upper
      assign first_vec[g] = hit_vec[g] && !(|hit_vec[g-1:0]);
    end
  end

  always_comb begin
    hit_idx = '0;
    for (int i = NUM_BAR - 1; i >= 0; i--) begin
      if (hit_vec[i]) hit_idx = BAR_IDX_W'(i);
    end
  end

  assign any_hit = |hit_vec;

endmodule

// File: rtl/ireq_lb_abort.sv
module ireq_lb_abort
  import ireq_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_valid,
  input  logic             rsp_timeout,
  input  logic             rsp_rderr,
  input  logic             rsp_np,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             cpl_valid,
  output logic [2:0]       cpl_status,
  output logic [TAG_W-1:0] cpl_tag,
  output logic             irq_abort
);

  logic need_cpl;
  logic timeout_evt;

  assign timeout_evt = rsp_valid && rsp_timeout;
  assign need_cpl    = rsp_valid && ((rsp_timeout && rsp_np) || (!rsp_timeout && rsp_rderr));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpl_valid  <= 1'b0;
      cpl_status <= CPL_SC;
      cpl_tag    <= '0;
      irq_abort  <= 1'b0;
    end else begin
      cpl_valid  <= need_cpl;
      irq_abort  <= timeout_evt;
      if (need_cpl) begin
        cpl_status <= CPL_CA;
        cpl_tag    <= rsp_tag;
      end
    end
  end

  // R10: an abort interrupt only follows a reported timeout
  p_abort_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_abort |-> $past(rsp_valid && rsp_timeout));

  // R11: every local-bus completion carries Completer Abort status
  p_abort_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> cpl_status == CPL_CA);

  // R11: a read error without timeout never raises the abort interrupt
  p_rderr_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rsp_valid && rsp_rderr && !rsp_timeout) |-> !irq_abort);

endmodule

// File: rtl/inb_req_checker.sv
module inb_req_checker
  import ireq_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int TAG_W     = 8,
  parameter int NUM_BAR   = 3,
  parameter int BAR_IDX_W = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hdr_valid,
  input  logic [2:0]                hdr_fmt,
  input  logic [4:0]                hdr_type,
  input  logic [ADDR_W-1:0]         hdr_addr,
  input  logic                      hdr_poison,
  input  logic [TAG_W-1:0]          hdr_tag,
  input  logic [NUM_BAR-1:0]        cfg_bar_en,
  input  logic [NUM_BAR*ADDR_W-1:0] cfg_bar_base,
  input  logic [NUM_BAR*ADDR_W-1:0] cfg_bar_mask,
  input  logic                      lb_rsp_valid,
  input  logic                      lb_rsp_timeout,
  input  logic                      lb_rsp_rderr,
  input  logic                      lb_rsp_np,
  input  logic [TAG_W-1:0]          lb_rsp_tag,
  output logic                      fwd_valid,
  output logic [ADDR_W-1:0]         fwd_addr,
  output logic [TAG_W-1:0]          fwd_tag,
  output logic [BAR_IDX_W-1:0]      fwd_bar,
  output logic                      fwd_write,
  output logic                      fwd_np,
  output logic                      hdr_cpl_valid,
  output logic [2:0]                hdr_cpl_status,
  output logic [TAG_W-1:0]          hdr_cpl_tag,
  output logic                      lb_cpl_valid,
  output logic [2:0]                lb_cpl_status,
  output logic [TAG_W-1:0]          lb_cpl_tag,
  output logic                      irq_unsup,
  output logic                      irq_abort,
  output logic                      irq_poison
);

  // Named internal events
  req_kind_e              kind;
  logic                   posted;
  logic                   is_write;
  logic                   msg_by_addr;
  logic [NUM_BAR-1:0]     hit_vec;
  logic [NUM_BAR-1:0]     first_vec;
  logic                   any_hit;
  logic [BAR_IDX_W-1:0]   hit_idx;
  decision_e              decision;
  logic                   type_fail;
  logic                   bar_fail;
  logic                   poison_fail;
  logic                   raise_unsup;

  ireq_classify u_classify (
    .fmt         (hdr_fmt),
    .typ         (hdr_type),
    .kind        (kind),
    .posted      (posted),
    .is_write    (is_write),
    .msg_by_addr (msg_by_addr)
  );

  ireq_bar_match #(
    .ADDR_W    (ADDR_W),
    .NUM_BAR   (NUM_BAR),
    .BAR_IDX_W (BAR_IDX_W)
  ) u_bar (
    .addr      (hdr_addr),
    .bar_en    (cfg_bar_en),
    .bar_base  (cfg_bar_base),
    .bar_mask  (cfg_bar_mask),
    .hit_vec   (hit_vec),
    .first_vec (first_vec),
    .any_hit   (any_hit),
    .hit_idx   (hit_idx)
  );

  // Ordered checks: type, then window, then poison; first failure wins.
  always_comb begin
    type_fail   = 1'b0;
    bar_fail    = 1'b0;
    poison_fail = 1'b0;
    raise_unsup = 1'b0;
    decision    = DEC_NONE;
    if (hdr_valid) begin
      if (kind != KIND_MEM) begin
        type_fail   = 1'b1;
        raise_unsup = msg_by_addr;
        decision    = posted ? DEC_DROP_SILENT : DEC_DROP_UR;
      end else if (!any_hit) begin
        bar_fail = 1'b1;
        decision = posted ? DEC_DROP_SILENT : DEC_DROP_UR;
      end else if (hdr_poison) begin
        poison_fail = 1'b1;
        decision    = DEC_DROP_POISON;
      end else begin
        decision = DEC_FORWARD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid      <= 1'b0;
      fwd_addr       <= '0;
      fwd_tag        <= '0;
      fwd_bar        <= '0;
      fwd_write      <= 1'b0;
      fwd_np         <= 1'b0;
      hdr_cpl_valid  <= 1'b0;
      hdr_cpl_status <= CPL_SC;
      hdr_cpl_tag    <= '0;
      irq_unsup      <= 1'b0;
      irq_poison     <= 1'b0;
    end else begin
      fwd_valid     <= (decision == DEC_FORWARD);
      hdr_cpl_valid <= (decision == DEC_DROP_UR);
      irq_unsup     <= raise_unsup;
      irq_poison    <= (decision == DEC_DROP_POISON);
      if (decision == DEC_FORWARD) begin
        fwd_addr  <= hdr_addr;
        fwd_tag   <= hdr_tag;
        fwd_bar   <= hit_idx;
        fwd_write <= is_write;
        fwd_np    <= !posted;
      end
      if (decision == DEC_DROP_UR) begin
        hdr_cpl_status <= CPL_UR;
        hdr_cpl_tag    <= hdr_tag;
      end
    end
  end

  ireq_lb_abort #(
    .TAG_W (TAG_W)
  ) u_lb_abort (
    .clk         (clk),
    .rst_n       (rst_n),
    .rsp_valid   (lb_rsp_valid),
    .rsp_timeout (lb_rsp_timeout),
    .rsp_rderr   (lb_rsp_rderr),
    .rsp_np      (lb_rsp_np),
    .rsp_tag     (lb_rsp_tag),
    .cpl_valid   (lb_cpl_valid),
    .cpl_status  (lb_cpl_status),
    .cpl_tag     (lb_cpl_tag),
    .irq_abort   (irq_abort)
  );

  // R1: no header-path output without a header in the previous cycle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hdr_valid) |-> !(fwd_valid || hdr_cpl_valid || irq_unsup || irq_poison));

  // R2: a forwarded request never also gets a completion or an interrupt
  p_fwd_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> !(hdr_cpl_valid || irq_unsup || irq_poison));

  // R3: the winning window is unique and is the one reported
  p_first_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(first_vec));
  p_first_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_hit |-> first_vec[hit_idx]);

  // R4: rejected-header completions carry Unsupported Request status
  p_ur_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_cpl_valid |-> hdr_cpl_status == CPL_UR);

  // R6: the unsupported-message interrupt never comes with a completion
  p_unsup_no_cpl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_unsup |-> !hdr_cpl_valid);

  // R8: a type or window failure never reaches the poison interrupt
  p_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (type_fail || bar_fail) |=> !irq_poison);

  // R9: a poisoned drop is neither forwarded nor completed
  p_poison_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    poison_fail |=> (irq_poison && !fwd_valid && !hdr_cpl_valid));

endmodule

// File: tb/test_inb_req_checker.sv
module test_inb_req_checker;

  localparam int ADDR_W  = 32;
  localparam int TAG_W   = 8;
  localparam int NUM_BAR = 3;
  localparam int BIW     = 2;

  logic                      clk = 1'b0;
  logic                      rst_n = 1'b0;
  logic                      hdr_valid = 1'b0;
  logic [2:0]                hdr_fmt = '0;
  logic [4:0]                hdr_type = '0;
  logic [ADDR_W-1:0]         hdr_addr = '0;
  logic                      hdr_poison = 1'b0;
  logic [TAG_W-1:0]          hdr_tag = '0;
  logic [NUM_BAR-1:0]        cfg_bar_en = 3'b111;
  logic [NUM_BAR*ADDR_W-1:0] cfg_bar_base = {32'h1000_0000, 32'h2000_0000, 32'h1000_0000};
  logic [NUM_BAR*ADDR_W-1:0] cfg_bar_mask = {32'hFF00_0000, 32'hFFF0_0000, 32'hFFFF_0000};
  logic                      lb_rsp_valid = 1'b0;
  logic                      lb_rsp_timeout = 1'b0;
  logic                      lb_rsp_rderr = 1'b0;
  logic                      lb_rsp_np = 1'b0;
  logic [TAG_W-1:0]          lb_rsp_tag = '0;
  logic                      fwd_valid;
  logic [ADDR_W-1:0]         fwd_addr;
  logic [TAG_W-1:0]          fwd_tag;
  logic [BIW-1:0]            fwd_bar;
  logic                      fwd_write;
  logic                      fwd_np;
  logic                      hdr_cpl_valid;
  logic [2:0]                hdr_cpl_status;
  logic [TAG_W-1:0]          hdr_cpl_tag;
  logic                      lb_cpl_valid;
  logic [2:0]                lb_cpl_status;
  logic [TAG_W-1:0]          lb_cpl_tag;
  logic                      irq_unsup;
  logic                      irq_abort;
  logic                      irq_poison;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  inb_req_checker #(
    .ADDR_W (ADDR_W), .TAG_W (TAG_W), .NUM_BAR (NUM_BAR)
  ) i_inb_req_checker (
    .clk (clk), .rst_n (rst_n),
    .hdr_valid (hdr_valid), .hdr_fmt (hdr_fmt), .hdr_type (hdr_type),
    .hdr_addr (hdr_addr), .hdr_poison (hdr_poison), .hdr_tag (hdr_tag),
    .cfg_bar_en (cfg_bar_en), .cfg_bar_base (cfg_bar_base), .cfg_bar_mask (cfg_bar_mask),
    .lb_rsp_valid (lb_rsp_valid), .lb_rsp_timeout (lb_rsp_timeout),
    .lb_rsp_rderr (lb_rsp_rderr), .lb_rsp_np (lb_rsp_np), .lb_rsp_tag (lb_rsp_tag),
    .fwd_valid (fwd_valid), .fwd_addr (fwd_addr), .fwd_tag (fwd_tag),
    .fwd_bar (fwd_bar), .fwd_write (fwd_write), .fwd_np (fwd_np),
    .hdr_cpl_valid (hdr_cpl_valid), .hdr_cpl_status (hdr_cpl_status),
    .hdr_cpl_tag (hdr_cpl_tag),
    .lb_cpl_valid (lb_cpl_valid), .lb_cpl_status (lb_cpl_status), .lb_cpl_tag (lb_cpl_tag),
    .irq_unsup (irq_unsup), .irq_abort (irq_abort), .irq_poison (irq_poison)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one header at a falling edge; return at the next falling edge, when results are visible.
  task automatic send_hdr(input logic [2:0] fmt, input logic [4:0] typ,
                          input logic [31:0] addr, input logic poison, input logic [7:0] tag);
    hdr_fmt = fmt; hdr_type = typ; hdr_addr = addr; hdr_poison = poison; hdr_tag = tag;
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
  endtask

  task automatic expect_hdr(input string req, input bit fwd, input bit cpl,
                            input bit unsup, input bit poi);
    check(req, "fwd_valid", fwd_valid, fwd);
    check(req, "hdr_cpl_valid", hdr_cpl_valid, cpl);
    check(req, "irq_unsup", irq_unsup, unsup);
    check(req, "irq_poison", irq_poison, poi);
  endtask

  task automatic send_lb(input bit tmo, input bit rderr, input bit np, input logic [7:0] tag);
    lb_rsp_timeout = tmo; lb_rsp_rderr = rderr; lb_rsp_np = np; lb_rsp_tag = tag;
    lb_rsp_valid = 1'b1;
    @(negedge clk);
    lb_rsp_valid = 1'b0;
  endtask

  task automatic t_reset;
    check("R1", "fwd_valid", fwd_valid, 0);
    check("R1", "hdr_cpl_valid", hdr_cpl_valid, 0);
    check("R1", "lb_cpl_valid", lb_cpl_valid, 0);
    check("R1", "irqs", {irq_unsup, irq_abort, irq_poison}, 0);
  endtask

  task automatic t_forward;
    send_hdr(3'b000, 5'b00000, 32'h2001_0040, 1'b0, 8'h11);  // R2 read in window 1
    expect_hdr("R2", 1, 0, 0, 0);
    check("R2", "fwd_addr", fwd_addr, 32'h2001_0040);
    check("R2", "fwd_tag", fwd_tag, 8'h11);
    check("R2", "fwd_bar", fwd_bar, 1);
    check("R2", "fwd_write", fwd_write, 0);
    check("R2", "fwd_np", fwd_np, 1);
    send_hdr(3'b011, 5'b00000, 32'h1080_0000, 1'b0, 8'h12);  // R2 write, only window 2
    expect_hdr("R2", 1, 0, 0, 0);
    check("R2", "fwd_write", fwd_write, 1);
    check("R2", "fwd_np", fwd_np, 0);
    check("R3", "fwd_bar", fwd_bar, 2);
    @(negedge clk);
    expect_hdr("R1", 0, 0, 0, 0);
  endtask

  task automatic t_priority;
    send_hdr(3'b000, 5'b00000, 32'h1000_1234, 1'b0, 8'h21);  // R3 windows 0 and 2 overlap
    check("R3", "fwd_valid", fwd_valid, 1);
    check("R3", "fwd_bar", fwd_bar, 0);
    cfg_bar_en = 3'b110;
    send_hdr(3'b000, 5'b00000, 32'h1000_1234, 1'b0, 8'h22);  // R3 window 0 disabled
    check("R3", "fwd_bar", fwd_bar, 2);
    cfg_bar_en = 3'b010;
    send_hdr(3'b000, 5'b00000, 32'h1000_1234, 1'b0, 8'h23);  // R3 both disabled -> miss
    expect_hdr("R3", 0, 1, 0, 0);
    cfg_bar_en = 3'b111;
  endtask

  task automatic t_miss;
    send_hdr(3'b001, 5'b00000, 32'h3000_0000, 1'b0, 8'h31);  // R4 read miss
    expect_hdr("R4", 0, 1, 0, 0);
    check("R4", "hdr_cpl_status", hdr_cpl_status, 3'b001);
    check("R4", "hdr_cpl_tag", hdr_cpl_tag, 8'h31);
    send_hdr(3'b010, 5'b00000, 32'h3000_0000, 1'b0, 8'h32);  // R4 write miss
    expect_hdr("R4", 0, 0, 0, 0);
  endtask

  task automatic t_io;
    send_hdr(3'b010, 5'b00010, 32'h2000_0010, 1'b0, 8'h41);  // R5 I/O write hitting window 1
    expect_hdr("R5", 0, 1, 0, 0);
    check("R5", "hdr_cpl_tag", hdr_cpl_tag, 8'h41);
    send_hdr(3'b000, 5'b00010, 32'h3000_0010, 1'b0, 8'h42);  // R5 I/O read, miss
    expect_hdr("R5", 0, 1, 0, 0);
  endtask

  task automatic t_msg;
    send_hdr(3'b001, 5'b10001, 32'h2000_0000, 1'b0, 8'h51);  // R6 address-routed message
    expect_hdr("R6", 0, 0, 1, 0);
    @(negedge clk);
    check("R6", "irq_unsup pulse", irq_unsup, 0);
    send_hdr(3'b011, 5'b10100, 32'h0, 1'b0, 8'h52);          // R6 local message
    expect_hdr("R6", 0, 0, 0, 0);
  endtask

  task automatic t_other;
    send_hdr(3'b000, 5'b00100, 32'h2000_0000, 1'b0, 8'h61);  // R7 config type
    expect_hdr("R7", 0, 1, 0, 0);
    check("R7", "hdr_cpl_tag", hdr_cpl_tag, 8'h61);
    send_hdr(3'b100, 5'b00000, 32'h2000_0000, 1'b0, 8'h62);  // R7 fmt[2]=1
    expect_hdr("R7", 0, 1, 0, 0);
  endtask

  task automatic t_order;
    send_hdr(3'b000, 5'b00000, 32'h3000_0000, 1'b1, 8'h71);  // R8 poisoned miss
    expect_hdr("R8", 0, 1, 0, 0);
    send_hdr(3'b010, 5'b00010, 32'h2000_0000, 1'b1, 8'h72);  // R8 poisoned I/O on hit
    expect_hdr("R8", 0, 1, 0, 0);
    send_hdr(3'b001, 5'b10001, 32'h2000_0000, 1'b1, 8'h73);  // R8 poisoned message
    expect_hdr("R8", 0, 0, 1, 0);
  endtask

  task automatic t_poison;
    send_hdr(3'b000, 5'b00000, 32'h2000_0100, 1'b1, 8'h81);  // R9 poisoned read hit
    expect_hdr("R9", 0, 0, 0, 1);
    @(negedge clk);
    check("R9", "irq_poison pulse", irq_poison, 0);
  endtask

  task automatic t_lb;
    send_lb(1'b1, 1'b0, 1'b1, 8'h91);                        // R10 non-posted timeout
    check("R10", "irq_abort", irq_abort, 1);
    check("R10", "lb_cpl_valid", lb_cpl_valid, 1);
    check("R10", "lb_cpl_status", lb_cpl_status, 3'b100);
    check("R10", "lb_cpl_tag", lb_cpl_tag, 8'h91);
    send_lb(1'b1, 1'b0, 1'b0, 8'h92);                        // R10 posted timeout
    check("R10", "irq_abort", irq_abort, 1);
    check("R10", "lb_cpl_valid", lb_cpl_valid, 0);
    send_lb(1'b0, 1'b1, 1'b1, 8'h93);                        // R11 read error
    check("R11", "irq_abort", irq_abort, 0);
    check("R11", "lb_cpl_valid", lb_cpl_valid, 1);
    check("R11", "lb_cpl_status", lb_cpl_status, 3'b100);
    check("R11", "lb_cpl_tag", lb_cpl_tag, 8'h93);
    @(negedge clk);
    check("R1", "lb idle", {lb_cpl_valid, irq_abort}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_forward;
    t_priority;
    t_miss;
    t_io;
    t_msg;
    t_other;
    t_order;
    t_poison;
    t_lb;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule